// File: doc/BRIEF.md
# Undo-Log Queue with Register Rollback

This block keeps precise machine state in a core that lets results land in the register file the moment they are produced, in whatever order execution finishes. Every instruction that enters the window takes one slot of a circular undo log. If the instruction names a destination register, the value that register holds at that moment is saved in the slot. When a result arrives it is written straight into the register file, and the slot is marked finished, with a fault flag when the result carries one.

Slots leave the log from the oldest end, in program order, one per cycle, once they are finished and free of faults. When the oldest slot is finished and faulted, the block stops accepting new instructions and keeps taking results until every slot in the window has finished. It then walks the log from the newest slot back to the oldest, one slot per cycle, and writes each saved value back into its register. After that walk the register file holds exactly the state from before the faulting instruction. A one-cycle pulse reports the faulting instruction's address, and new instructions are accepted again. A registered read port shows the contents of the register file.

Top module: `undo_queue`

## Requirements
- R1: After reset the log is empty, `disp_ready` is 1, `issue_halt` and `recov_done` are 0, `disp_tag` is 0 and every register reads 0.
- R2: An instruction is accepted in a cycle where `disp_valid` and `disp_ready` are both 1. It takes the slot shown on `disp_tag` in that cycle, and `disp_tag` then advances by one modulo DEPTH (DEPTH is a power of two).
- R3: A completion (`cmp_valid`, with `cmp_idx` naming the slot) writes `cmp_data` at once into the destination register of that slot, whatever the order of completions. The new value shows on `rd_data` one cycle after `rd_addr` selects the register.
- R4: A slot dispatched with `disp_has_dst` = 0 writes no register when it completes, and it writes nothing during rollback.
- R5: A finished, fault-free slot at the oldest end is freed, one per cycle, in program order.
- R6: When DEPTH-1 slots are occupied, `disp_ready` is 0 and a `disp_valid` request is ignored: `disp_tag` does not move.
- R7: When the oldest slot is finished with a fault, `disp_ready` drops in that same cycle and `issue_halt` rises one cycle later. Completions are still taken and written to the register file until every occupied slot has finished.
- R8: Once every slot has finished, rollback starts on the next cycle. It restores one slot per cycle, from the newest slot to the oldest, and includes the faulting slot. The register file ends with the values held before the faulting instruction was dispatched.
- R9: At the end of rollback, `recov_done` is high for exactly one cycle with `recov_pc` equal to the faulting instruction's address. In that cycle `issue_halt` is 0, `disp_ready` is 1 and `disp_tag` equals the faulting slot, so the log is empty.
- R10: When a completion writes register X in the same cycle that a new instruction with destination X is dispatched, the new slot saves the value just completed.
- R11: A completion that names an unoccupied slot changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | New instruction request |
| disp_pc | input | PCW | Address of the new instruction |
| disp_has_dst | input | 1 | New instruction writes a register |
| disp_dst | input | log2(NREG) | Destination register number |
| disp_ready | output | 1 | A request is accepted this cycle |
| disp_tag | output | log2(DEPTH) | Slot given to the instruction accepted this cycle |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | log2(DEPTH) | Slot that completes |
| cmp_exc | input | 1 | Completion carries a fault |
| cmp_data | input | XLEN | Result value |
| rd_addr | input | log2(NREG) | Register to observe |
| rd_data | output | XLEN | Registered contents of `rd_addr` |
| issue_halt | output | 1 | Fault handling in progress |
| recov_done | output | 1 | One-cycle pulse at the end of rollback |
| recov_pc | output | PCW | Address of the faulting instruction |

## Verification
A completion changes the register file at the clock edge where it is taken, and `rd_data` follows on the next edge. The bench therefore drives its inputs on a falling edge and compares the read port one full cycle after it sets `rd_addr`. `disp_ready` falls in the cycle right after the faulting completion is taken, and `issue_halt` one cycle after that, so each is checked at its own falling edge. After the last outstanding completion the bench counts falling edges until `recov_done` appears. It expects one cycle to enter rollback plus one cycle per occupied slot, and it checks `recov_pc`, `disp_tag` and the restored registers in the pulse cycle and right after it.

// File: rtl/undo_pkg.sv
package undo_pkg;
  // Fault handling phases of the log controller.
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,  // accept, complete, free
    ST_DRAIN = 2'd1,  // oldest slot faulted; wait for all slots to finish
    ST_ROLL  = 2'd2   // walk newest to oldest restoring saved values
  } undo_state_e;
endpackage

// File: rtl/undo_lutram.sv
// Small storage array: one synchronous write port and NRD asynchronous read
// ports, written so that distributed RAM can be inferred.
module undo_lutram #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*W +: W] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/undo_regfile.sv
// Architectural register file: one write port, one combinational read for
// saving old values, one registered read for observation.
module undo_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RW-1:0]   sv_addr,
  output logic [XLEN-1:0] sv_data,
  input  logic [RW-1:0]   ob_addr,
  output logic [XLEN-1:0] ob_data
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ob_data <= '0;
    else     ob_data <= regs[ob_addr];
  end

  assign sv_data = regs[sv_addr];
endmodule

// File: rtl/undo_ctrl.sv
// Pointers, per-slot status bits and the fault/rollback sequencer.
module undo_ctrl
  import undo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_valid,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_idx,
  input  logic          cmp_exc,
  output logic          disp_fire,
  output logic          cmp_fire,
  output logic          roll_fire,
  output logic          fault_enter,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [IW-1:0] roll_idx,
  output logic          disp_ready,
  output logic          issue_halt,
  output logic          recov_done
);
  undo_state_e      state_q;
  logic [IW-1:0]    head_q, tail_q;
  logic [DEPTH-1:0] vld_q, done_q, exc_q;
  logic             recov_q;

  logic full, head_fault, retire, all_done;

  assign full       = (tail_q + 1'b1) == head_q;
  assign head_fault = vld_q[head_q] & done_q[head_q] & exc_q[head_q];
  assign all_done   = &(done_q | ~vld_q);
  assign retire     = (state_q == ST_RUN) & vld_q[head_q] & done_q[head_q]
                      & ~exc_q[head_q];

  assign disp_ready  = (state_q == ST_RUN) & ~full & ~head_fault;
  assign disp_fire   = disp_valid & disp_ready;
  assign cmp_fire    = cmp_valid & vld_q[cmp_idx] & (state_q != ST_ROLL);
  assign roll_fire   = (state_q == ST_ROLL);
  assign roll_idx    = tail_q - 1'b1;
  assign fault_enter = (state_q == ST_RUN) & head_fault;

  assign head       = head_q;
  assign tail       = tail_q;
  assign issue_halt = (state_q != ST_RUN);
  assign recov_done = recov_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      head_q  <= '0;
      tail_q  <= '0;
      vld_q   <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      recov_q <= 1'b0;
    end else begin
      recov_q <= 1'b0;
      if (disp_fire) begin
        vld_q[tail_q]  <= 1'b1;
        done_q[tail_q] <= 1'b0;
        exc_q[tail_q]  <= 1'b0;
        tail_q         <= tail_q + 1'b1;
      end
      if (cmp_fire) begin
        done_q[cmp_idx] <= 1'b1;
        exc_q[cmp_idx]  <= cmp_exc;
      end
      if (retire) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      case (state_q)
        ST_RUN:   if (head_fault) state_q <= ST_DRAIN;
        ST_DRAIN: if (all_done)   state_q <= ST_ROLL;
        ST_ROLL: begin
          vld_q[roll_idx] <= 1'b0;
          tail_q          <= roll_idx;
          if (roll_idx == head_q) begin
            state_q <= ST_RUN;
            recov_q <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/undo_queue.sv
// Top: undo log with saved register values and backward rollback.
module undo_queue #(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG),
  localparam int MW   = RW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_valid,
  input  logic [PCW-1:0]  disp_pc,
  input  logic            disp_has_dst,
  input  logic [RW-1:0]   disp_dst,
  output logic            disp_ready,
  output logic [IW-1:0]   disp_tag,
  input  logic            cmp_valid,
  input  logic [IW-1:0]   cmp_idx,
  input  logic            cmp_exc,
  input  logic [XLEN-1:0] cmp_data,
  input  logic [RW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            issue_halt,
  output logic            recov_done,
  output logic [PCW-1:0]  recov_pc
);
  logic          disp_fire, cmp_fire, roll_fire, fault_enter;
  logic [IW-1:0] head, tail, roll_idx;

  undo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .cmp_valid  (cmp_valid),
    .cmp_idx    (cmp_idx),
    .cmp_exc    (cmp_exc),
    .disp_fire  (disp_fire),
    .cmp_fire   (cmp_fire),
    .roll_fire  (roll_fire),
    .fault_enter(fault_enter),
    .head       (head),
    .tail       (tail),
    .roll_idx   (roll_idx),
    .disp_ready (disp_ready),
    .issue_halt (issue_halt),
    .recov_done (recov_done)
  );

  assign disp_tag = tail;

  // Destination metadata: read for the rollback slot and the completing slot.
  logic [2*MW-1:0] meta_rd;
  logic            roll_has, cmp_has;
  logic [RW-1:0]   roll_dst, cmp_dst;

  undo_lutram #(.W(MW), .DEPTH(DEPTH), .NRD(2)) u_meta (
    .clk  (clk),
    .we   (disp_fire),
    .waddr(tail),
    .wdata({disp_has_dst, disp_dst}),
    .raddr({cmp_idx, roll_idx}),
    .rdata(meta_rd)
  );
  assign {roll_has, roll_dst} = meta_rd[MW-1:0];
  assign {cmp_has, cmp_dst}   = meta_rd[2*MW-1:MW];

  // Saved old values: read only during rollback.
  logic [XLEN-1:0] old_wr, roll_old;

  undo_lutram #(.W(XLEN), .DEPTH(DEPTH), .NRD(1)) u_old (
    .clk  (clk),
    .we   (disp_fire),
    .waddr(tail),
    .wdata(old_wr),
    .raddr(roll_idx),
    .rdata(roll_old)
  );

  // Instruction addresses: read at the oldest slot for fault reporting.
  logic [PCW-1:0] head_pc;

  undo_lutram #(.W(PCW), .DEPTH(DEPTH), .NRD(1)) u_pc (
    .clk  (clk),
    .we   (disp_fire),
    .waddr(tail),
    .wdata(disp_pc),
    .raddr(head),
    .rdata(head_pc)
  );

  // Register file write: rollback restore and completions never overlap.
  logic            cmp_wr, rf_we;
  logic [RW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata, rf_cur;

  assign cmp_wr = cmp_fire & cmp_has;

  always_comb begin
    if (roll_fire) begin
      rf_we    = roll_has;
      rf_waddr = roll_dst;
      rf_wdata = roll_old;
    end else begin
      rf_we    = cmp_wr;
      rf_waddr = cmp_dst;
      rf_wdata = cmp_data;
    end
  end

  undo_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .sv_addr(disp_dst),
    .sv_data(rf_cur),
    .ob_addr(rd_addr),
    .ob_data(rd_data)
  );

  // Save the value as it stands after any same-cycle completion to that register.
  assign old_wr = (cmp_wr && (cmp_dst == disp_dst)) ? cmp_data : rf_cur;

  always_ff @(posedge clk) begin
    if (rst)              recov_pc <= '0;
    else if (fault_enter) recov_pc <= head_pc;
  end
endmodule

// File: rtl/undo_queue_chk.sv
module undo_queue_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [IW-1:0] disp_tag,
  input logic          issue_halt,
  input logic          recov_done
);
  // R2: an accepted instruction advances the tag by one
  a_r2_tag_step: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |=> disp_tag == IW'($past(disp_tag) + 1'b1));

  // R6: a refused request in normal operation leaves the tag in place
  a_r6_stall_holds_tag: assert property (@(posedge clk) disable iff (rst)
    (!disp_ready && !issue_halt) |=> disp_tag == $past(disp_tag));

  // R7: no instruction is accepted while fault handling runs
  a_r7_halt_blocks: assert property (@(posedge clk) disable iff (rst)
    issue_halt |-> !disp_ready);

  // R9: the end-of-recovery pulse lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    recov_done |=> !recov_done);

  // R9: the pulse comes out of a halted period and reopens dispatch
  a_r9_after_halt: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_done) |-> $past(issue_halt));

  a_r9_reopens: assert property (@(posedge clk) disable iff (rst)
    recov_done |-> (disp_ready && !issue_halt));
endmodule

bind undo_queue undo_queue_chk #(.IW(IW)) u_undo_chk (
  .clk       (clk),
  .rst       (rst),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .disp_tag  (disp_tag),
  .issue_halt(issue_halt),
  .recov_done(recov_done)
);

// File: tb/undo_queue_test.sv
module undo_queue_test;
  localparam int IW = 3;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          disp_valid = 1'b0;
  logic [31:0]   disp_pc = '0;
  logic          disp_has_dst = 1'b0;
  logic [RW-1:0] disp_dst = '0;
  logic          disp_ready;
  logic [IW-1:0] disp_tag;
  logic          cmp_valid = 1'b0;
  logic [IW-1:0] cmp_idx = '0;
  logic          cmp_exc = 1'b0;
  logic [31:0]   cmp_data = '0;
  logic [RW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          issue_halt, recov_done;
  logic [31:0]   recov_pc;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  undo_queue uut (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_has_dst(disp_has_dst),
    .disp_dst(disp_dst), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_exc(cmp_exc),
    .cmp_data(cmp_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .issue_halt(issue_halt), .recov_done(recov_done), .recov_pc(recov_pc)
  );

  // Vector: {op[3:0], a[3:0], f[3:0], d[31:0]}
  // op 0 dispatch (a=dst, f[0]=has dst, d=pc); op 1 complete (a=slot, f[0]=fault, d=data)
  // op 2 read and compare (a=reg, d=expected); op 3 idle cycle
  localparam int NV = 17;
  localparam logic [43:0] VEC [NV] = '{
    {4'd0, 4'd1, 4'd1, 32'h0000_0100},
    {4'd1, 4'd0, 4'd0, 32'h0000_0011},
    {4'd3, 4'd0, 4'd0, 32'h0},
    {4'd2, 4'd1, 4'd0, 32'h0000_0011},
    {4'd0, 4'd2, 4'd1, 32'h0000_0104},
    {4'd0, 4'd3, 4'd1, 32'h0000_0108},
    {4'd0, 4'd0, 4'd0, 32'h0000_010C},
    {4'd1, 4'd2, 4'd0, 32'h0000_0033},
    {4'd2, 4'd3, 4'd0, 32'h0000_0033},
    {4'd2, 4'd2, 4'd0, 32'h0},
    {4'd1, 4'd1, 4'd0, 32'h0000_0022},
    {4'd1, 4'd3, 4'd0, 32'h0000_DEAD},
    {4'd2, 4'd2, 4'd0, 32'h0000_0022},
    {4'd2, 4'd0, 4'd0, 32'h0},
    {4'd3, 4'd0, 4'd0, 32'h0},
    {4'd3, 4'd0, 4'd0, 32'h0},
    {4'd3, 4'd0, 4'd0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic disp(input logic [31:0] pc, input logic has, input logic [RW-1:0] dst);
    disp_valid = 1'b1; disp_pc = pc; disp_has_dst = has; disp_dst = dst;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic cmpl(input logic [IW-1:0] idx, input logic exc, input logic [31:0] data);
    cmp_valid = 1'b1; cmp_idx = idx; cmp_exc = exc; cmp_data = data;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_exc = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [RW-1:0] r, input logic [31:0] exp);
    rd_addr = r;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic wait_recov(output int n);
    n = 0;
    while (!recov_done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'b0, disp_ready}, 32'd1);
    chk("R1 halt", {31'b0, issue_halt}, 32'd0);
    chk("R1 done", {31'b0, recov_done}, 32'd0);
    chk("R1 tag", {29'b0, disp_tag}, 32'd0);
    rdchk("R1 reg", 4'd7, 32'h0);

    // Table: in-order and out-of-order completions (R2, R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      case (v[43:40])
        4'd0: begin
          chk("R2 ready before dispatch", {31'b0, disp_ready}, 32'd1);
          disp(v[31:0], v[32], v[39:36]);
        end
        4'd1: cmpl(v[38:36], v[32], v[31:0]);
        4'd2: rdchk("R3/R4 table read", v[39:36], v[31:0]);
        default: @(negedge clk);
      endcase
    end
    // R5: all four slots freed in order, log empty at slot 4
    chk("R5 tag after frees", {29'b0, disp_tag}, 32'd4);
    chk("R5 ready", {31'b0, disp_ready}, 32'd1);

    // R11: completion for a free slot (slot 1 last named r2) is ignored
    cmpl(3'd1, 1'b0, 32'h0000_0099);
    rdchk("R11 stale completion", 4'd2, 32'h0000_0022);

    // Fault and rollback: slots 4..7
    disp(32'h200, 1'b1, 4'd1);
    disp(32'h204, 1'b1, 4'd2);
    disp(32'h208, 1'b1, 4'd1);
    disp(32'h20C, 1'b0, 4'd0);
    cmpl(3'd4, 1'b1, 32'h0000_00A1);
    chk("R7 ready drops", {31'b0, disp_ready}, 32'd0);
    rdchk("R3 faulting result written", 4'd1, 32'h0000_00A1);
    chk("R7 halt", {31'b0, issue_halt}, 32'd1);
    cmpl(3'd6, 1'b0, 32'h0000_00C1);
    cmpl(3'd5, 1'b0, 32'h0000_00B2);
    rdchk("R7 completion during drain", 4'd1, 32'h0000_00C1);
    rdchk("R7 completion during drain", 4'd2, 32'h0000_00B2);
    cmpl(3'd7, 1'b0, 32'h0000_0777);
    wait_recov(n);
    chk("R8 cycles to recovery", n, 32'd5);
    chk("R9 pulse", {31'b0, recov_done}, 32'd1);
    chk("R9 pc", recov_pc, 32'h200);
    chk("R9 tag", {29'b0, disp_tag}, 32'd4);
    chk("R9 ready", {31'b0, disp_ready}, 32'd1);
    chk("R9 halt", {31'b0, issue_halt}, 32'd0);
    @(negedge clk);
    chk("R9 single pulse", {31'b0, recov_done}, 32'd0);
    rdchk("R8 r1 restored", 4'd1, 32'h0000_0011);
    rdchk("R8 r2 restored", 4'd2, 32'h0000_0022);
    rdchk("R4 r0 untouched", 4'd0, 32'h0);

    // R6: fill seven slots (4,5,6,7,0,1,2)
    for (int k = 0; k < 7; k++) disp(32'h400 + 32'(k) * 4, 1'b0, 4'd0);
    chk("R6 full", {31'b0, disp_ready}, 32'd0);
    chk("R6 tag at full", {29'b0, disp_tag}, 32'd3);
    disp(32'h4FF, 1'b0, 4'd0);
    chk("R6 refused request", {29'b0, disp_tag}, 32'd3);
    cmpl(3'd4, 1'b0, 32'h0);
    @(negedge clk);
    chk("R6 ready after free", {31'b0, disp_ready}, 32'd1);
    for (int k = 5; k < 10; k++) cmpl(3'(k), 1'b0, 32'h0);
    cmpl(3'd2, 1'b0, 32'h0);
    repeat (8) @(negedge clk);

    // R10: same-cycle completion and dispatch to r5
    disp(32'h300, 1'b1, 4'd5);          // slot 3
    cmp_valid = 1'b1; cmp_idx = 3'd3; cmp_exc = 1'b0; cmp_data = 32'h55;
    disp(32'h304, 1'b1, 4'd5);          // slot 4, same cycle
    cmp_valid = 1'b0;
    cmpl(3'd4, 1'b1, 32'h77);
    rdchk("R3 r5 faulting value", 4'd5, 32'h77);
    wait_recov(n);
    chk("R10 pc", recov_pc, 32'h304);
    @(negedge clk);
    rdchk("R10 saved bypassed value", 4'd5, 32'h55);

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule